// File: doc/BRIEF.md
# Programmable Chip-Select Address Decoder

This block turns each bus access into at most one active-low chip select. It has eight channels. Each channel holds a 16-bit base that is compared with the upper address bits, a 32-bit mask word and a 16-bit settings word. The upper half of the mask word lists the address bits to ignore. Its lower half holds access qualifiers, a write-protect bit and a valid bit. A valid channel is selected when the address matches its base in every unmasked bit and no qualifier bars the access type. The decoder then presents that channel's wait-state count, auto-acknowledge, port width, byte-enable mode and burst enables to the external bus timing engine, which is outside this block.

After reset the decoder is in boot mode. In boot mode channel 0 answers every access, so code can be fetched before any channel is programmed. Software programs the other channels first. It then writes channel 0's mask word with the valid bit set, which ends boot mode for good.

Accesses arrive as a plain `acc_valid` strobe and are never stalled. The decoder takes one access per cycle and has no back-pressure. Results appear on registered outputs in the next cycle. Register writes use a simple write-only port: a channel index, a register selector and a 32-bit data word.

Top module: `csdec_top`

## Requirements
- R1: A valid channel matches when `(acc_addr[31:16] ^ base) & ~mask[31:16]` is zero, so base 0x0040 with mask 0x001F covers 0x00400000 through 0x005FFFFF.
- R2: A channel whose valid bit (mask bit 0) is clear never asserts its select once boot mode has ended.
- R3: Each access type has a blocking bit in the mask word. Interrupt acknowledge is blocked by bit 5. User data is blocked by bit 1 and supervisor data by bit 2. User code is blocked by bit 3 and supervisor code by bit 4. A blocked access does not select the channel.
- R4: If the winning channel has write protect (mask bit 6) set and the access is a write, no select asserts and `wp_err` pulses for that cycle's result. Reads to the same channel still select it.
- R5: When several channels match, the lowest-numbered one wins. At most one select is low in any cycle.
- R6: From reset until channel 0's mask word is written with bit 0 set, channel 0 alone asserts for every access and ignores base, mask and qualifiers. Clearing that bit later does not restart boot mode.
- R7: The settings outputs carry the winning channel's settings word: waits = bits 3:0, auto-ack = bit 4, port width = bits 6:5 (00 = 32-bit, 01 = 8-bit, 10 = 16-bit), byte-enable mode = bit 7, burst read = bit 8, burst write = bit 9. The outputs are all zero when no select asserts. Channel 0's settings word resets to 0x001F and all other registers reset to zero.
- R8: Selects, settings and `wp_err` are registered and reflect the access presented on the previous clock edge. A cycle with `acc_valid` low yields no select and no error.
- R9: During reset and right after it, all selects are high and `wp_err` is low.
- R10: A write with `reg_sel` = 0 loads the base from `reg_wdata[15:0]`, `reg_sel` = 1 loads the mask word, `reg_sel` = 2 loads the settings from `reg_wdata[15:0]`, and `reg_sel` = 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_ch | input | 3 | Channel index of the write |
| reg_sel | input | 2 | Register selector (0 base, 1 mask, 2 settings) |
| reg_wdata | input | 32 | Write data |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | Access is a write |
| acc_super | input | 1 | Access is in supervisor mode |
| acc_code | input | 1 | Access is an instruction fetch |
| acc_iack | input | 1 | Access is an interrupt acknowledge |
| cs_n | output | 8 | Active-low selects, one per channel |
| sel_waits | output | 4 | Wait-state count of the winner |
| sel_aa | output | 1 | Auto-acknowledge enable of the winner |
| sel_ps | output | 2 | Port width code of the winner |
| sel_bem | output | 1 | Byte-enable mode of the winner |
| sel_bstr | output | 1 | Burst-read enable of the winner |
| sel_bstw | output | 1 | Burst-write enable of the winner |
| wp_err | output | 1 | Write to a write-protected range |

## Verification
Some properties are checked on every cycle. At most one select is low. A protection error never comes with a select. An idle cycle produces nothing. Boot mode never comes back once it ends. A channel that is invalid outside boot stays quiet. Only the bench's scenarios show the address arithmetic of overlapping ranges, the priority choice, the per-type qualifier blocking, the exact settings fields and the point where boot mode hands over to channel 0. These need a reference model of the programmed registers, which the bench keeps.

// File: rtl/csdec_pkg.sv
package csdec_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BASE_W = 16;
  localparam int unsigned SET_W  = 16;

  // qualifier positions in the low half of the mask word
  localparam int unsigned MQ_V  = 0;
  localparam int unsigned MQ_UD = 1;
  localparam int unsigned MQ_SD = 2;
  localparam int unsigned MQ_UC = 3;
  localparam int unsigned MQ_SC = 4;
  localparam int unsigned MQ_CI = 5;
  localparam int unsigned MQ_WP = 6;

  typedef struct packed {
    logic [3:0] waits;
    logic       aa;
    logic [1:0] ps;
    logic       bem;
    logic       bstr;
    logic       bstw;
  } sel_cfg_t;

  function automatic sel_cfg_t set_decode(input logic [SET_W-1:0] s);
    sel_cfg_t c;
    c.waits = s[3:0];
    c.aa    = s[4];
    c.ps    = s[6:5];
    c.bem   = s[7];
    c.bstr  = s[8];
    c.bstw  = s[9];
    return c;
  endfunction
endpackage

// File: rtl/csdec_regs.sv
module csdec_regs
  import csdec_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter logic [SET_W-1:0] BOOT_SET = 16'h001F,
  localparam int unsigned CHW = $clog2(NCH)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [CHW-1:0]                ch,
  input  logic [1:0]                    sel,
  input  logic [DATA_W-1:0]             wdata,
  output logic [NCH-1:0][BASE_W-1:0]    base_o,
  output logic [NCH-1:0][DATA_W-1:0]    mask_o,
  output logic [NCH-1:0][SET_W-1:0]     set_o,
  output logic                          boot_o
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [SET_W-1:0] SET_RST = (i == 0) ? BOOT_SET : '0;
    logic hit_w;
    assign hit_w = we && (ch == CHW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_o[i] <= '0;
        mask_o[i] <= '0;
        set_o[i]  <= SET_RST;
      end else if (hit_w) begin
        case (sel)
          2'd0: base_o[i] <= wdata[BASE_W-1:0];
          2'd1: mask_o[i] <= wdata;
          2'd2: set_o[i]  <= wdata[SET_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) boot_o <= 1'b1;
    else if (we && ch == '0 && sel == 2'd1 && wdata[MQ_V]) boot_o <= 1'b0;
  end

  // R6: boot mode once left never returns
  a_r6_boot_no_return: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_o |=> !boot_o);
endmodule

// File: rtl/csdec_match.sv
module csdec_match
  import csdec_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter bit IS_BOOT = 1'b0
) (
  input  logic [BASE_W-1:0] base,
  input  logic [DATA_W-1:0] mask,
  input  logic              boot,
  input  logic [AW-1:0]     addr,
  input  logic              wr,
  input  logic              sup,
  input  logic              code,
  input  logic              iack,
  output logic              hit,
  output logic              wp
);
  logic [BASE_W-1:0] diff;
  logic addr_ok, blocked;

  assign diff    = (addr[AW-1 -: BASE_W] ^ base) & ~mask[DATA_W-1 -: BASE_W];
  assign addr_ok = (diff == '0);

  always_comb begin
    if (iack)      blocked = mask[MQ_CI];
    else if (code) blocked = sup ? mask[MQ_SC] : mask[MQ_UC];
    else           blocked = sup ? mask[MQ_SD] : mask[MQ_UD];
  end

  always_comb begin
    if (boot) begin
      hit = IS_BOOT;
      wp  = 1'b0;
    end else begin
      hit = mask[MQ_V] && addr_ok && !blocked;
      wp  = mask[MQ_WP] && wr;
    end
  end
endmodule

// File: rtl/csdec_arb.sv
module csdec_arb
  import csdec_pkg::*;
#(
  parameter int unsigned NCH = 8,
  localparam int unsigned CHW = $clog2(NCH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      valid,
  input  logic [NCH-1:0]            hit,
  input  logic [NCH-1:0]            wp,
  input  logic [NCH-1:0][SET_W-1:0] set_i,
  output logic [NCH-1:0]            cs_n,
  output sel_cfg_t                  cfg,
  output logic                      err
);
  logic [CHW-1:0] win;
  logic           any;
  logic           block;

  always_comb begin
    win = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (hit[i]) win = CHW'(i);
    end
  end

  assign any   = valid && (hit != '0);
  assign block = any && wp[win];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n <= '1;
      cfg  <= '0;
      err  <= 1'b0;
    end else begin
      cs_n <= '1;
      cfg  <= '0;
      err  <= block;
      if (any && !block) begin
        cs_n[win] <= 1'b0;
        cfg       <= set_decode(set_i[win]);
      end
    end
  end

  a_r5_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  a_r4_err_no_select: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (&cs_n));
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> ((&cs_n) && !err));
  a_r7_cfg_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n) |-> (cfg == '0));
endmodule

// File: rtl/csdec_top.sv
module csdec_top
  import csdec_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned AW  = 32,
  parameter logic [15:0] BOOT_SET = 16'h001F,
  localparam int unsigned CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [CHW-1:0] reg_ch,
  input  logic [1:0]     reg_sel,
  input  logic [31:0]    reg_wdata,
  input  logic           acc_valid,
  input  logic [AW-1:0]  acc_addr,
  input  logic           acc_write,
  input  logic           acc_super,
  input  logic           acc_code,
  input  logic           acc_iack,
  output logic [NCH-1:0] cs_n,
  output logic [3:0]     sel_waits,
  output logic           sel_aa,
  output logic [1:0]     sel_ps,
  output logic           sel_bem,
  output logic           sel_bstr,
  output logic           sel_bstw,
  output logic           wp_err
);
  logic [NCH-1:0][BASE_W-1:0] base;
  logic [NCH-1:0][DATA_W-1:0] mask;
  logic [NCH-1:0][SET_W-1:0]  sets;
  logic                       boot;
  logic [NCH-1:0]             hit, wp;
  sel_cfg_t                   cfg;

  csdec_regs #(.NCH(NCH), .BOOT_SET(BOOT_SET)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .ch(reg_ch), .sel(reg_sel),
    .wdata(reg_wdata), .base_o(base), .mask_o(mask), .set_o(sets),
    .boot_o(boot)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_match
    csdec_match #(.AW(AW), .IS_BOOT(i == 0)) u_m (
      .base(base[i]), .mask(mask[i]), .boot(boot), .addr(acc_addr),
      .wr(acc_write), .sup(acc_super), .code(acc_code), .iack(acc_iack),
      .hit(hit[i]), .wp(wp[i])
    );

    // R2: an invalid channel outside boot mode stays deasserted
    a_r2_invalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!boot && !mask[i][MQ_V]) |=> cs_n[i]);
  end

  csdec_arb #(.NCH(NCH)) u_arb (
    .clk(clk), .rst_n(rst_n), .valid(acc_valid), .hit(hit), .wp(wp),
    .set_i(sets), .cs_n(cs_n), .cfg(cfg), .err(wp_err)
  );

  assign sel_waits = cfg.waits;
  assign sel_aa    = cfg.aa;
  assign sel_ps    = cfg.ps;
  assign sel_bem   = cfg.bem;
  assign sel_bstr  = cfg.bstr;
  assign sel_bstw  = cfg.bstw;

  a_r6_boot_claims: assert property (@(posedge clk) disable iff (!rst_n)
    (boot && acc_valid) |=> (!cs_n[0] && !wp_err));
endmodule

// File: tb/sim_csdec_top.sv
module sim_csdec_top;
  localparam int NCH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_ch = '0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_write = 1'b0, acc_super = 1'b0, acc_code = 1'b0, acc_iack = 1'b0;
  logic [NCH-1:0] cs_n;
  logic [3:0]  sel_waits;
  logic        sel_aa, sel_bem, sel_bstr, sel_bstw, wp_err;
  logic [1:0]  sel_ps;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_base [NCH];
  logic [31:0] m_mask [NCH];
  logic [15:0] m_set  [NCH];
  logic        m_boot;

  always #5 clk = ~clk;

  csdec_top u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_ch(reg_ch),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_write(acc_write), .acc_super(acc_super),
    .acc_code(acc_code), .acc_iack(acc_iack), .cs_n(cs_n),
    .sel_waits(sel_waits), .sel_aa(sel_aa), .sel_ps(sel_ps),
    .sel_bem(sel_bem), .sel_bstr(sel_bstr), .sel_bstw(sel_bstw),
    .wp_err(wp_err)
  );

  function automatic logic [9:0] fields(input logic [15:0] s);
    return {s[3:0], s[4], s[6:5], s[7], s[8], s[9]};
  endfunction

  // expected {cs_n, settings, err}
  function automatic logic [18:0] expect_of(input logic v, input logic [31:0] a,
      input logic w, input logic s, input logic c, input logic i);
    logic [7:0] cs;
    logic blk;
    cs = 8'hFF;
    if (!v) return {8'hFF, 10'd0, 1'b0};
    if (m_boot) return {8'hFE, fields(m_set[0]), 1'b0};
    for (int k = 0; k < NCH; k++) begin
      if (i)      blk = m_mask[k][5];
      else if (c) blk = s ? m_mask[k][4] : m_mask[k][3];
      else        blk = s ? m_mask[k][2] : m_mask[k][1];
      if (m_mask[k][0] && !blk &&
          (((a[31:16] ^ m_base[k]) & ~m_mask[k][31:16]) == 16'd0)) begin
        if (m_mask[k][6] && w) return {8'hFF, 10'd0, 1'b1};
        cs[k] = 1'b0;
        return {cs, fields(m_set[k]), 1'b0};
      end
    end
    return {8'hFF, 10'd0, 1'b0};
  endfunction

  task automatic check(input string req, input logic [18:0] act, input logic [18:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got cs_n=%h set=%h err=%b, expected cs_n=%h set=%h err=%b",
               req, act[18:11], act[10:1], act[0], exp[18:11], exp[10:1], exp[0]);
    end
  endtask

  task automatic wr(input int ch, input int sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_ch = 3'(ch); reg_sel = 2'(sel); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    case (sel)
      0: m_base[ch] = d[15:0];
      1: begin m_mask[ch] = d; if (ch == 0 && d[0]) m_boot = 1'b0; end
      2: m_set[ch] = d[15:0];
      default: ;
    endcase
  endtask

  task automatic acc(input string req, input logic v, input logic [31:0] a,
      input logic w, input logic s, input logic c, input logic i);
    logic [18:0] exp;
    @(negedge clk);
    exp = expect_of(v, a, w, s, c, i);
    acc_valid = v; acc_addr = a; acc_write = w; acc_super = s; acc_code = c; acc_iack = i;
    @(negedge clk);
    acc_valid = 1'b0;
    check(req, {cs_n, sel_waits, sel_aa, sel_ps, sel_bem, sel_bstr, sel_bstw, wp_err}, exp);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int dummy;
    dummy = $urandom(32'd1234);
    for (int k = 0; k < NCH; k++) begin
      m_base[k] = '0; m_mask[k] = '0; m_set[k] = (k == 0) ? 16'h001F : 16'h0000;
    end
    m_boot = 1'b1;
    repeat (3) @(negedge clk);
    check("R9", {cs_n, sel_waits, sel_aa, sel_ps, sel_bem, sel_bstr, sel_bstw, wp_err},
          {8'hFF, 10'd0, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", {cs_n, sel_waits, sel_aa, sel_ps, sel_bem, sel_bstr, sel_bstw, wp_err},
          {8'hFF, 10'd0, 1'b0});

    // R6 boot claims all, R7 boot settings
    acc("R6", 1'b1, 32'h1234_5678, 1'b1, 1'b0, 1'b0, 1'b0);
    acc("R7", 1'b1, 32'hFFFF_FFF0, 1'b0, 1'b1, 1'b1, 1'b1);
    acc("R8", 1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0);
    wr(0, 2, 32'h0000_03B2);
    acc("R7", 1'b1, 32'h0040_0000, 1'b0, 1'b0, 1'b0, 1'b0);

    // program channels before leaving boot
    wr(3, 0, 32'h0000_0040); wr(3, 2, 32'h0000_00A0); wr(3, 1, 32'h001F_0001);
    acc("R6", 1'b1, 32'h0040_0000, 1'b0, 1'b0, 1'b0, 1'b0);
    wr(0, 0, 32'h0000_FF00); wr(0, 1, 32'h00FF_0001);
    acc("R1", 1'b1, 32'h0040_0000, 1'b0, 1'b0, 1'b0, 1'b0);
    acc("R1", 1'b1, 32'h005F_FFFC, 1'b0, 1'b1, 1'b0, 1'b0);
    acc("R1", 1'b1, 32'h0060_0000, 1'b0, 1'b0, 1'b0, 1'b0);
    acc("R1", 1'b1, 32'h003F_FFFC, 1'b0, 1'b0, 1'b0, 1'b0);
    acc("R1", 1'b1, 32'hFF80_0000, 1'b0, 1'b0, 1'b0, 1'b0);
    acc("R8", 1'b0, 32'h0040_0000, 1'b0, 1'b0, 1'b0, 1'b0);

    // R5 overlap priority
    wr(2, 0, 32'h0000_0040); wr(2, 2, 32'h0000_0155); wr(2, 1, 32'h003F_0001);
    acc("R5", 1'b1, 32'h0040_0000, 1'b0, 1'b0, 1'b0, 1'b0);
    acc("R5", 1'b1, 32'h0070_0000, 1'b0, 1'b0, 1'b0, 1'b0);

    // R2 invalid channel
    wr(4, 0, 32'h0000_1000); wr(4, 2, 32'h0000_000F); wr(4, 1, 32'h0000_0000);
    acc("R2", 1'b1, 32'h1000_0000, 1'b0, 1'b0, 1'b0, 1'b0);

    // R3 qualifiers: SD and CI blocked on channel 5
    wr(5, 0, 32'h0000_2000); wr(5, 2, 32'h0000_0203); wr(5, 1, 32'h0000_0025);
    acc("R3", 1'b1, 32'h2000_0010, 1'b0, 1'b1, 1'b0, 1'b0);
    acc("R3", 1'b1, 32'h2000_0010, 1'b0, 1'b0, 1'b0, 1'b0);
    acc("R3", 1'b1, 32'h2000_0010, 1'b0, 1'b1, 1'b1, 1'b0);
    acc("R3", 1'b1, 32'h2000_0010, 1'b0, 1'b0, 1'b0, 1'b1);

    // R4 write protect on channel 6
    wr(6, 0, 32'h0000_3000); wr(6, 2, 32'h0000_0007); wr(6, 1, 32'h0000_0041);
    acc("R4", 1'b1, 32'h3000_0000, 1'b0, 1'b0, 1'b0, 1'b0);
    acc("R4", 1'b1, 32'h3000_0000, 1'b1, 1'b0, 1'b0, 1'b0);
    acc("R4", 1'b1, 32'h3000_0004, 1'b0, 1'b1, 1'b1, 1'b0);

    // R10 selector 3 is ignored
    wr(6, 3, 32'h0000_0000);
    acc("R10", 1'b1, 32'h3000_0000, 1'b0, 1'b0, 1'b0, 1'b0);
    wr(6, 0, 32'h0000_3100);
    acc("R10", 1'b1, 32'h3100_0000, 1'b0, 1'b0, 1'b0, 1'b0);

    // R6 clearing channel 0 valid does not restart boot
    wr(0, 1, 32'h00FF_0000);
    acc("R6", 1'b1, 32'h1234_0000, 1'b0, 1'b0, 1'b0, 1'b0);

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 3) == 0) begin
        int ch, sel;
        logic [31:0] d;
        ch  = $urandom_range(0, NCH - 1);
        sel = $urandom_range(0, 3);
        case (sel)
          0: d = {16'h0, 8'h00, 4'($urandom_range(0, 15)), 4'h0};
          1: d = {8'h00, 8'(8'h0F << $urandom_range(0, 4)) & 8'h3F,
                  9'h0, 7'($urandom) | 7'($urandom_range(0, 3) != 0)};
          default: d = $urandom;
        endcase
        wr(ch, sel, d);
      end else begin
        logic [31:0] a;
        a = {8'h00, 8'($urandom), 16'($urandom)};
        acc("R1", 1'($urandom_range(0, 7) != 0), a, 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom_range(0, 7) == 0));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule